// File: doc/BRIEF.md
# One-Wire Scratchpad Memory Responder

This block is the device side of a bit-serial single-wire memory. A host does not drive line timing directly. It pulses one of three strobes: send a 0 bit, send a 1 bit, or reset the bus. It can also issue a poll strobe, which stands for one read of the device status. The responder assembles bits into bytes with the least-significant bit first. It decodes a command from the first byte after each bus reset. It returns a read-data bit and a busy flag.

Inside there is a 512-byte memory and a 32-byte scratchpad. A three-byte header goes with the scratchpad: two target-address bytes and an ending-offset/status byte. Data always passes through the scratchpad on its way into memory. The host writes the scratchpad, reads it back together with its header, and then authorises a copy into memory by echoing the header exactly. Memory contents can be streamed out from any address.

Top module: `owr_spad_resp`

## Requirements
- R1: Bits arrive least-significant first and eight bit strobes make one byte. The first byte after a bus reset is the command. A command byte of 0xCC is consumed, and the following byte is then taken as the command.
- R2: Every bit strobe raises `busy`. `busy` falls after exactly 3 poll strobes that follow the last bit strobe, provided no copy is running.
- R3: Command 0x0F clears all 32 scratchpad bytes to zero. It is followed by a target address (low byte, then high byte). Data byte i is stored in slot (address + i) mod 32.
- R4: A bus reset that ends a 0x0F transfer after its address is complete updates the header. Header byte 0 is the address low byte and byte 1 is the high byte. Byte 2 bits 4:0 hold the last slot written, (address + n - 1) mod 32, for n data bytes. Bit 6 is set when n > 32, bit 5 is set when n < 32, and bit 7 is 0.
- R5: Command 0xAA returns header bytes 0, 1 and 2 in that order. It then returns scratchpad slots starting at (address mod 32) and wrapping modulo 32, without end.
- R6: While the device is transmitting, each bit strobe places the next bit (least-significant first) on `rd_bit`, one cycle after the strobe.
- R7: Command 0x55 followed by three bytes equal to header bytes 0, 1 and 2 copies slots (address mod 32) through the ending slot, with wrap, to memory location (address with its low 5 bits cleared) + slot. It then sets bit 7 of header byte 2 and drives `rd_bit` to 0.
- R8: Command 0x55 with any authorisation byte that differs from the header leaves memory and the header unchanged.
- R9: Command 0xF0 followed by an address (low byte first) streams memory bytes from that address upward. Addresses of 512 and above read as 0xFF.
- R10: A bus reset discards a partly received byte, clears the command state, returns the device to receive direction and sets `rd_bit` to 1.
- R11: After an unrecognised command, all further bytes are ignored until a bus reset. Out of reset, `busy` is 0 and `rd_bit` is 1.
- R12: `busy` stays high while an accepted copy is moving bytes, even after the poll count has run out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr0_stb | input | 1 | One-cycle strobe: host sends a 0 bit (also a read slot) |
| wr1_stb | input | 1 | One-cycle strobe: host sends a 1 bit (also a read slot) |
| bus_rst_stb | input | 1 | One-cycle strobe: bus reset, has priority over bit strobes |
| poll_stb | input | 1 | One-cycle strobe: host reads device status |
| rd_bit | output | 1 | Data bit returned to the host |
| busy | output | 1 | Device busy flag |

## Verification
A wrong slot index or a lost wrap shows up in the next 0xAA read-back of the scratchpad. The read-back happens a few hundred strobes after the write, at the first data byte that sits past the wrap point. A wrong header status or a faulty authorisation compare changes what header byte 2 returns, or makes a later memory read of the copied window differ byte by byte. A bit counter that slips, or that is not cleared by a bus reset, corrupts the very next command. All later read data then differ from the first returned byte on. The bench sweeps start offsets that cover both wrap and no-wrap cases, and data lengths of 0, 1, short, 31, 32, 33 and 40 bytes.

// File: rtl/owr_pkg.sv
// owr_pkg: command codes and the sequencer state type shared by the
// one-wire scratchpad responder. Assumes 8-bit command bytes.
package owr_pkg;

    localparam logic [7:0] OWR_CMD_SKIP = 8'hCC;
    localparam logic [7:0] OWR_CMD_WSP  = 8'h0F;
    localparam logic [7:0] OWR_CMD_RSP  = 8'hAA;
    localparam logic [7:0] OWR_CMD_CSP  = 8'h55;
    localparam logic [7:0] OWR_CMD_RMEM = 8'hF0;

    typedef enum logic [3:0] {
        SQ_CMD,
        SQ_WA0,
        SQ_WA1,
        SQ_WDAT,
        SQ_RSP,
        SQ_CA0,
        SQ_CA1,
        SQ_CA2,
        SQ_COPY,
        SQ_MA0,
        SQ_MA1,
        SQ_MRD,
        SQ_IGN
    } owr_seq_t;

endpackage

// File: rtl/owr_bit_shift.sv
// owr_bit_shift: assembles received bits LSB first into bytes and selects
// the outgoing bit of a transmit byte by the same bit counter.
// Assumes at most one strobe per cycle; clr has priority over stb.
module owr_bit_shift #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          stb,
    input  logic          din,
    input  logic [BW-1:0] tx_byte,
    output logic [BW-1:0] rx_byte,
    output logic          byte_done,
    output logic          tx_bit
);
    localparam int CW = $clog2(BW);

    logic [BW-1:0] sh_q;
    logic [CW-1:0] cnt_q;

    // Byte including the bit arriving this cycle.
    assign rx_byte   = {din, sh_q[BW-1:1]};
    assign byte_done = stb && (cnt_q == CW'(BW - 1));
    assign tx_bit    = tx_byte[cnt_q];

    // Shift register and bit counter update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (stb) begin
            sh_q  <= rx_byte;
            cnt_q <= byte_done ? '0 : cnt_q + CW'(1);
        end
    end

    // R10: a bus reset leaves the bit counter at zero.
    a_r10_clear_count: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    // R1: the eighth bit closes a byte and restarts the count.
    a_r1_byte_restart: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> (cnt_q == '0));

endmodule

// File: rtl/owr_busy_timer.sv
// owr_busy_timer: busy flag loaded by each bit strobe and run down by
// status polls; an external hold keeps it high (copy in progress).
// Assumes POLLS >= 1.
module owr_busy_timer #(
    parameter int POLLS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic poll,
    input  logic hold,
    output logic busy
);
    localparam int TW = $clog2(POLLS + 1);

    logic [TW-1:0] cnt_q;
    logic          pend;

    assign pend = (cnt_q != '0);
    assign busy = pend || hold;

    // Reload on a bit strobe, count down on polls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= TW'(POLLS);
        end else if (poll && pend) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    // R2: the poll count only falls because of a poll.
    a_r2_fall_on_poll: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend) |-> $past(poll));

    // R2: a bit strobe always raises busy.
    a_r2_load_raises: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);

endmodule

// File: rtl/owr_spad_store.sv
// owr_spad_store: scratchpad storage with one write port, two read ports
// and a single-cycle clear. Assumes clr and we are not asked together
// (clr wins).
module owr_spad_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] widx,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] ridx_a,
    output logic [DW-1:0]            rdata_a,
    input  logic [$clog2(DEPTH)-1:0] ridx_b,
    output logic [DW-1:0]            rdata_b
);
    logic [DEPTH-1:0][DW-1:0] cells_q;

    assign rdata_a = cells_q[ridx_a];
    assign rdata_b = cells_q[ridx_b];

    // Clear or single-slot write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cells_q <= '0;
        end else if (we) begin
            cells_q[widx] <= wdata;
        end
    end

    // R3: a write-scratchpad command leaves every slot zero.
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cells_q == '0));

endmodule

// File: rtl/owr_spad_resp.sv
// owr_spad_resp: device side of a bit-serial one-wire memory with a
// scratchpad, header and authorised copy into a byte memory.
// Assumes one-cycle strobes, at most one bit strobe per cycle, and
// SPAD_BYTES <= 32 so the ending offset fits bits 4:0 of the status byte.
module owr_spad_resp
    import owr_pkg::*;
#(
    parameter int MEM_BYTES  = 512,
    parameter int SPAD_BYTES = 32,
    parameter int BUSY_POLLS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr0_stb,
    input  logic wr1_stb,
    input  logic bus_rst_stb,
    input  logic poll_stb,
    output logic rd_bit,
    output logic busy
);
    localparam int MEM_AW = $clog2(MEM_BYTES);
    localparam int SLOT_W = $clog2(SPAD_BYTES);
    localparam int CNT_W  = SLOT_W + 2;
    localparam int ADDR_W = 16;

    owr_seq_t          seq_q;
    logic [ADDR_W-1:0] ta_q, wta_q, maddr_q;
    logic [7:0]        es_q, es_new;
    logic [SLOT_W-1:0] wslot_q, rsp_slot_q, cp_slot_q;
    logic [CNT_W-1:0]  wcnt_q;
    logic [1:0]        rsp_ph_q;
    logic              auth_ok_q;
    logic              rd_bit_q;

    logic              bit_stb, tx_mode, byte_done, tx_bit;
    logic [7:0]        rx_byte, tx_byte, sp_rd_a, sp_rd_b, mem_rd;
    logic              sp_clr, sp_we;

    logic [7:0]        mem_q [MEM_BYTES];

    assign bit_stb = (wr0_stb || wr1_stb) && !bus_rst_stb;
    assign tx_mode = (seq_q == SQ_RSP) || (seq_q == SQ_MRD);
    assign sp_clr  = byte_done && (seq_q == SQ_CMD) && (rx_byte == OWR_CMD_WSP);
    assign sp_we   = byte_done && (seq_q == SQ_WDAT);
    assign rd_bit  = rd_bit_q;

    owr_bit_shift #(.BW(8)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (bus_rst_stb),
        .stb       (bit_stb),
        .din       (wr1_stb),
        .tx_byte   (tx_byte),
        .rx_byte   (rx_byte),
        .byte_done (byte_done),
        .tx_bit    (tx_bit)
    );

    owr_busy_timer #(.POLLS(BUSY_POLLS)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (bit_stb),
        .poll  (poll_stb),
        .hold  (seq_q == SQ_COPY),
        .busy  (busy)
    );

    owr_spad_store #(.DEPTH(SPAD_BYTES), .DW(8)) u_spad (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sp_clr),
        .we      (sp_we),
        .widx    (wslot_q),
        .wdata   (rx_byte),
        .ridx_a  (rsp_slot_q),
        .rdata_a (sp_rd_a),
        .ridx_b  (cp_slot_q),
        .rdata_b (sp_rd_b)
    );

    // Memory read port for the streaming read.
    assign mem_rd = mem_q[maddr_q[MEM_AW-1:0]];

    // Byte presented to the host in transmit states.
    always_comb begin
        tx_byte = 8'hFF;
        if (seq_q == SQ_RSP) begin
            case (rsp_ph_q)
                2'd0:    tx_byte = ta_q[7:0];
                2'd1:    tx_byte = ta_q[15:8];
                2'd2:    tx_byte = es_q;
                default: tx_byte = sp_rd_a;
            endcase
        end else if (seq_q == SQ_MRD) begin
            tx_byte = (maddr_q >= ADDR_W'(MEM_BYTES)) ? 8'hFF : mem_rd;
        end
    end

    // Ending offset and length flags for the header update.
    always_comb begin
        es_new             = '0;
        es_new[SLOT_W-1:0] = wslot_q - SLOT_W'(1);
        es_new[5]          = (wcnt_q < CNT_W'(SPAD_BYTES));
        es_new[6]          = (wcnt_q > CNT_W'(SPAD_BYTES));
    end

    // Copy engine: one scratchpad slot into memory per cycle.
    always_ff @(posedge clk) begin
        if (seq_q == SQ_COPY && !bus_rst_stb) begin
            mem_q[{ta_q[MEM_AW-1:SLOT_W], cp_slot_q}] <= sp_rd_b;
        end
    end

    // Command and byte sequencer with header, pointers and read bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q      <= SQ_CMD;
            ta_q       <= '0;
            es_q       <= '0;
            wta_q      <= '0;
            wslot_q    <= '0;
            wcnt_q     <= '0;
            rsp_ph_q   <= '0;
            rsp_slot_q <= '0;
            cp_slot_q  <= '0;
            auth_ok_q  <= 1'b0;
            maddr_q    <= '0;
            rd_bit_q   <= 1'b1;
        end else if (bus_rst_stb) begin
            if (seq_q == SQ_WDAT) begin
                ta_q <= wta_q;
                es_q <= es_new;
            end
            seq_q    <= SQ_CMD;
            rsp_ph_q <= '0;
            rd_bit_q <= 1'b1;
        end else begin
            if (bit_stb && tx_mode) begin
                rd_bit_q <= tx_bit;
            end
            if (seq_q == SQ_COPY) begin
                cp_slot_q <= cp_slot_q + SLOT_W'(1);
                if (cp_slot_q == es_q[SLOT_W-1:0]) begin
                    es_q[7] <= 1'b1;
                    seq_q   <= SQ_IGN;
                end
            end
            if (byte_done) begin
                case (seq_q)
                    SQ_CMD: begin
                        case (rx_byte)
                            OWR_CMD_SKIP: seq_q <= SQ_CMD;
                            OWR_CMD_WSP:  seq_q <= SQ_WA0;
                            OWR_CMD_RSP: begin
                                seq_q    <= SQ_RSP;
                                rsp_ph_q <= '0;
                            end
                            OWR_CMD_CSP: begin
                                seq_q     <= SQ_CA0;
                                auth_ok_q <= 1'b1;
                            end
                            OWR_CMD_RMEM: seq_q <= SQ_MA0;
                            default:      seq_q <= SQ_IGN;
                        endcase
                    end
                    SQ_WA0: begin
                        wta_q[7:0] <= rx_byte;
                        seq_q      <= SQ_WA1;
                    end
                    SQ_WA1: begin
                        wta_q[15:8] <= rx_byte;
                        wslot_q     <= wta_q[SLOT_W-1:0];
                        wcnt_q      <= '0;
                        seq_q       <= SQ_WDAT;
                    end
                    SQ_WDAT: begin
                        wslot_q <= wslot_q + SLOT_W'(1);
                        if (wcnt_q != {CNT_W{1'b1}}) begin
                            wcnt_q <= wcnt_q + CNT_W'(1);
                        end
                    end
                    SQ_RSP: begin
                        if (rsp_ph_q == 2'd2) begin
                            rsp_ph_q   <= 2'd3;
                            rsp_slot_q <= ta_q[SLOT_W-1:0];
                        end else if (rsp_ph_q == 2'd3) begin
                            rsp_slot_q <= rsp_slot_q + SLOT_W'(1);
                        end else begin
                            rsp_ph_q <= rsp_ph_q + 2'd1;
                        end
                    end
                    SQ_CA0: begin
                        auth_ok_q <= auth_ok_q && (rx_byte == ta_q[7:0]);
                        seq_q     <= SQ_CA1;
                    end
                    SQ_CA1: begin
                        auth_ok_q <= auth_ok_q && (rx_byte == ta_q[15:8]);
                        seq_q     <= SQ_CA2;
                    end
                    SQ_CA2: begin
                        if (auth_ok_q && (rx_byte == es_q)) begin
                            seq_q     <= SQ_COPY;
                            cp_slot_q <= ta_q[SLOT_W-1:0];
                            rd_bit_q  <= 1'b0;
                        end else begin
                            seq_q <= SQ_IGN;
                        end
                    end
                    SQ_MA0: begin
                        maddr_q[7:0] <= rx_byte;
                        seq_q        <= SQ_MA1;
                    end
                    SQ_MA1: begin
                        maddr_q[15:8] <= rx_byte;
                        seq_q         <= SQ_MRD;
                    end
                    SQ_MRD: begin
                        if (maddr_q != {ADDR_W{1'b1}}) begin
                            maddr_q <= maddr_q + ADDR_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R7: the last slot of an accepted copy marks the status byte.
    a_r7_copy_marks_status: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q == SQ_COPY && cp_slot_q == es_q[SLOT_W-1:0] && !bus_rst_stb) |=> es_q[7]);

    // R4: overflow and partial flags never appear together.
    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(es_q[6] && es_q[5]));

    // R10: a bus reset returns to command decode with the read bit high.
    a_r10_back_to_receive: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_stb |=> ((seq_q == SQ_CMD) && rd_bit_q));

    // R12: an accepted copy holds busy high.
    a_r12_busy_in_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q == SQ_COPY) |-> busy);

endmodule

// File: tb/test_owr_spad_resp.sv
`timescale 1ns/1ps
module test_owr_spad_resp;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr0_stb = 1'b0, wr1_stb = 1'b0, bus_rst_stb = 1'b0, poll_stb = 1'b0;
    logic rd_bit, busy;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    logic [7:0]  spad_m [32];
    logic [7:0]  mem_m  [512];
    logic [15:0] ta_m;
    logic [7:0]  es_m;

    always #10 clk = ~clk;

    owr_spad_resp i_owr_spad_resp (
        .clk(clk), .rst_n(rst_n), .wr0_stb(wr0_stb), .wr1_stb(wr1_stb),
        .bus_rst_stb(bus_rst_stb), .poll_stb(poll_stb),
        .rd_bit(rd_bit), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic b);
        @(negedge clk);
        wr1_stb = b;
        wr0_stb = !b;
        @(negedge clk);
        wr1_stb = 1'b0;
        wr0_stb = 1'b0;
    endtask

    task automatic poll();
        @(negedge clk);
        poll_stb = 1'b1;
        @(negedge clk);
        poll_stb = 1'b0;
    endtask

    task automatic bus_reset();
        @(negedge clk);
        bus_rst_stb = 1'b1;
        @(negedge clk);
        bus_rst_stb = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) strobe(v[i]);
    endtask

    task automatic recv_byte(output logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            strobe(1'b1);
            v[i] = rd_bit;
        end
    endtask

    // R3 R4: write n bytes from address ta, then end with a bus reset.
    task automatic do_write(input int ta, input int n, input int seed);
        logic [7:0] d;
        bus_reset();
        send_byte(8'h0F);
        send_byte(8'(ta));
        send_byte(8'(ta >> 8));
        for (int s = 0; s < 32; s++) spad_m[s] = 8'h00;
        for (int i = 0; i < n; i++) begin
            d = 8'((i * 29 + seed * 11 + 5) ^ (i >> 2));
            send_byte(d);
            spad_m[(ta + i) & 31] = d;
        end
        bus_reset();
        ta_m = 16'(ta);
        es_m = 8'((ta + n - 1) & 31);
        if (n > 32) es_m = es_m | 8'h40;
        if (n < 32) es_m = es_m | 8'h20;
    endtask

    // R5 R6: read back header and 33 data bytes (one past the wrap).
    task automatic verify_spad(input string tag);
        logic [7:0] v;
        bus_reset();
        send_byte(8'hAA);
        recv_byte(v); chk({"R5 hdr0 ", tag}, v, ta_m[7:0]);
        recv_byte(v); chk({"R5 hdr1 ", tag}, v, ta_m[15:8]);
        recv_byte(v); chk({"R4 status ", tag}, v, es_m);
        for (int k = 0; k < 33; k++) begin
            recv_byte(v);
            chk({"R5 R3 slot ", tag}, v, spad_m[(ta_m + k) & 31]);
        end
    endtask

    // R7 R8 R12: copy, with correct or corrupted authorisation.
    task automatic do_copy(input bit good, input bit full_window);
        int s;
        bus_reset();
        send_byte(8'h55);
        send_byte(ta_m[7:0]);
        send_byte(ta_m[15:8]);
        send_byte(good ? es_m : (es_m ^ 8'h01));
        chk("R8 R7 busy after copy command", busy, 1);
        if (good) begin
            chk("R7 read bit driven low", rd_bit, 0);
            s = ta_m & 31;
            for (int k = 0; k < 32; k++) begin
                mem_m[(ta_m & 16'h1E0) + 16'(s)] = spad_m[s];
                if (s == (es_m & 31)) break;
                s = (s + 1) & 31;
            end
            es_m = es_m | 8'h80;
        end
        if (full_window) begin
            poll(); poll(); poll();
            chk("R12 busy held during copy", busy, 1);
        end
        repeat (40) @(negedge clk);
        poll(); poll(); poll();
        chk("R2 busy cleared after copy and polls", busy, 0);
    endtask

    // R9: stream memory from addr.
    task automatic verify_mem(input int addr, input int count, input string tag);
        logic [7:0] v;
        bus_reset();
        send_byte(8'hF0);
        send_byte(8'(addr));
        send_byte(8'(addr >> 8));
        for (int k = 0; k < count; k++) begin
            recv_byte(v);
            chk({"R9 memory ", tag}, v, (addr + k < 512) ? mem_m[addr + k] : 8'hFF);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state.
        chk("R11 busy after reset", busy, 0);
        chk("R11 rd_bit after reset", rd_bit, 1);

        // R2: busy runs down after exactly three polls.
        bus_reset();
        strobe(1'b1);
        chk("R2 busy after strobe", busy, 1);
        poll(); poll();
        chk("R2 busy after two polls", busy, 1);
        poll();
        chk("R2 busy after three polls", busy, 0);
        strobe(1'b0);
        chk("R2 busy reloaded", busy, 1);
        poll(); poll(); poll(); poll();
        chk("R2 busy stays low on extra poll", busy, 0);

        // Fill all memory through full-window writes and copies.
        for (int w = 0; w < 16; w++) begin
            do_write(w * 32, 32, w);
            do_copy(1'b1, 1'b1);
        end
        verify_mem(0, 512, "full image");

        // Sweep start offsets and lengths.
        foreach (mem_m[j]) if (j < 0) mem_m[j] = 8'h00;
        for (int a = 0; a < 4; a++) begin
            for (int ni = 0; ni < 7; ni++) begin
                int ta, n;
                ta = (a == 0) ? 3 : (a == 1) ? 31 : (a == 2) ? 16'h1E5 : 16'h111;
                n  = (ni == 0) ? 0 : (ni == 1) ? 1 : (ni == 2) ? 5 : (ni == 3) ? 31 :
                     (ni == 4) ? 32 : (ni == 5) ? 33 : 40;
                do_write(ta, n, a * 7 + ni);
                verify_spad("sweep");
                do_copy(1'b1, 1'b0);
                verify_spad("after copy");
                verify_mem(ta & 16'h1E0, 32, "copied window");
            end
        end

        // R8: corrupted authorisation leaves memory and header alone.
        do_write(16'h0A7, 12, 99);
        do_copy(1'b0, 1'b0);
        verify_spad("R8 rejected copy");
        verify_mem(16'h0A0, 32, "R8 untouched window");

        // R9: reading across the end of memory returns 0xFF.
        verify_mem(16'h1FE, 4, "end of memory");

        // R1: skip code before the command.
        bus_reset();
        send_byte(8'hCC);
        send_byte(8'hAA);
        recv_byte(v); chk("R1 skip then read header byte 0", v, ta_m[7:0]);

        // R10: a partial byte is dropped by a bus reset.
        bus_reset();
        strobe(1'b1); strobe(1'b1); strobe(1'b1);
        bus_reset();
        chk("R10 rd_bit high after reset", rd_bit, 1);
        send_byte(8'hAA);
        recv_byte(v); chk("R10 header after partial byte", v, ta_m[7:0]);

        // R11: bytes after an unknown command are ignored.
        bus_reset();
        send_byte(8'h12);
        send_byte(8'h0F); send_byte(8'h05); send_byte(8'h00);
        send_byte(8'h77); send_byte(8'h66);
        recv_byte(v); chk("R11 no data after unknown command", v, 8'hFF);
        verify_spad("R11 header unchanged");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule